// File: doc/BRIEF.md
# Byte Subtract, Negate and Multiply Unit

This unit is the arithmetic slice of an accumulator-based core that handles every form of subtraction, two's-complement negation and the 8x8 multiply. Each cycle it accepts an operation code, the accumulator value, a register-file operand and the incoming carry. One clock edge later it presents a byte result, a double-width product and the five status flags. A per-flag update mask tells the surrounding core which flags that operation defines.

The carry flag follows the inverted-borrow convention: it is 1 when a subtraction needs no borrow. A forward form subtracts the accumulator from the operand. Two borrow forms are provided, one for each operand order, and each takes away the inverse of the incoming carry. Running the forward form on the low bytes and then the accumulator-first borrow form on the high bytes gives a correct 16-bit difference. The multiplier is unsigned, and the product sits in its own register pair. Operand width, the nibble boundary used for the half-carry and the multiplier structure are all parameters.

Top module: `alu_snm_unit`

## Requirements
- R1: While rst_n is low, and on the first edge after it, result_o, product_o, every flag and flag_upd_o are 0.
- R2: Op code 3'b001 (forward subtract) produces result_o = opnd_i - acc_i (mod 256) one clock later, regardless of carry_i.
- R3: Op code 3'b010 (accumulator-first borrow subtract) produces result_o = acc_i - opnd_i - (1 - carry_i) (mod 256) one clock later.
- R4: Op code 3'b011 (operand-first borrow subtract) produces result_o = opnd_i - acc_i - (1 - carry_i) (mod 256) one clock later.
- R5: Op code 3'b100 (negate) produces result_o = 0 - opnd_i (mod 256) one clock later. Negating 0 gives 0 with C=1, and negating 0x80 gives 0x80 with OV=1 and C=0.
- R6: After any subtract or negate, flag_c_o is 1 exactly when the exact difference is 0 or greater (no borrow). flag_dc_o is 1 exactly when the difference of the low nibbles, less the same borrow, is 0 or greater. For example, 1-0 gives 1 with C=1, 1-1 gives 0 with C=1, and 1-2 gives 0xFF with C=0.
- R7: After any subtract or negate, flag_ov_o is 1 exactly when the signed difference lies outside -128..127. flag_n_o equals bit 7 of the result, and flag_z_o is 1 exactly when the result is 0.
- R8: Op code 3'b101 (multiply) loads product_o with the unsigned product acc_i*opnd_i one clock later. result_o and all five flags hold their values, and flag_upd_o is 0.
- R9: A subtract or negate sets flag_upd_o to 5'b11111 (bit order N,OV,Z,DC,C from bit 4 down to bit 0) and leaves product_o unchanged.
- R10: Op codes 3'b000, 3'b110 and 3'b111 are idle. They change neither result_o, product_o nor any flag, and flag_upd_o is 0.
- R11: A forward subtract on the low bytes, followed by an accumulator-first borrow subtract on the high bytes that takes its carry from the previous flag_c_o, gives the 16-bit difference, and the final C is 1 exactly when no 16-bit borrow occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Register-file operand |
| carry_i | input | 1 | Incoming carry (inverted borrow) |
| result_o | output | 8 | Byte result of subtract or negate |
| product_o | output | 16 | Multiply product, high byte above low byte |
| flag_n_o | output | 1 | Negative flag |
| flag_ov_o | output | 1 | Signed overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_dc_o | output | 1 | Half (nibble) carry flag |
| flag_c_o | output | 1 | Carry flag, 1 means no borrow |
| flag_upd_o | output | 5 | Flags defined by the last operation |

## Verification
Every output sits one register away from its inputs. Any fault in the operand steering, the carry chain or the flag logic therefore shows up on the very next cycle as a wrong result, flag or update mask. A fault in the hold logic of the result or product registers shows up one cycle after an operation that should have left them alone. Most arithmetic faults depend on the data, so the sweep walks every accumulator value against a spread of operands for each op code and carry-in, and also crosses the nibble and sign boundaries. A wrong carry sense would surface in the chained 16-bit subtractions as an off-by-one in the high byte.

// File: rtl/alu_snm_pkg.sv
package alu_snm_pkg;

   typedef enum logic [2:0] {
      OP_IDLE   = 3'b000,
      OP_SUB    = 3'b001,
      OP_SUBB_W = 3'b010,
      OP_SUBB_F = 3'b011,
      OP_NEG    = 3'b100,
      OP_MUL    = 3'b101,
      OP_RSV6   = 3'b110,
      OP_RSV7   = 3'b111
   } op_e;

   localparam int FLG_C  = 0;
   localparam int FLG_DC = 1;
   localparam int FLG_Z  = 2;
   localparam int FLG_OV = 3;
   localparam int FLG_N  = 4;
   localparam int NUM_FLAGS = 5;

endpackage

// File: rtl/alu_snm_sub.sv
// Inverted-borrow subtractor a - b - !cin, built as a + ~b + cin,
// split at the nibble boundary to expose the half carry.
module alu_snm_sub #(
   parameter int W = 8,
   parameter int H = W / 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] res_o,
   output logic         cout_o,
   output logic         hcout_o,
   output logic         ovf_o
);
   localparam int HW = W - H;

   logic [H:0]  lo_sum;
   logic [HW:0] hi_sum;
   logic [W-1:0] b_inv;

   always_comb begin
      b_inv   = ~b_i;
      lo_sum  = {1'b0, a_i[H-1:0]} + {1'b0, b_inv[H-1:0]} + {{H{1'b0}}, cin_i};
      hi_sum  = {1'b0, a_i[W-1:H]} + {1'b0, b_inv[W-1:H]} + {{HW{1'b0}}, lo_sum[H]};
      res_o   = {hi_sum[HW-1:0], lo_sum[H-1:0]};
      cout_o  = hi_sum[HW];
      hcout_o = lo_sum[H];
      ovf_o   = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
   end

   // R6: equal operands with no incoming borrow never borrow
   always_comb begin
      if (cin_i && (a_i == b_i))
         assert_equal_no_borrow_R6: assert (cout_o && hcout_o && (res_o == '0));
   end

endmodule

// File: rtl/alu_snm_mul.sv
// Unsigned W x W multiplier; USE_ARRAY selects a shift-add array
// instead of the inferred operator.
module alu_snm_mul #(
   parameter int W = 8,
   parameter bit USE_ARRAY = 1'b1
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [2*W-1:0] p_o
);
   localparam int PW = 2 * W;

   generate
      if (USE_ARRAY) begin : g_array
         logic [PW-1:0] pp [W];
         for (genvar i = 0; i < W; i++) begin : g_pp
            assign pp[i] = b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0;
         end
         always_comb begin
            p_o = '0;
            for (int k = 0; k < W; k++) p_o = p_o + pp[k];
         end
      end else begin : g_oper
         assign p_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
      end
   endgenerate

   // R8: parity of the product's low bit follows the operands' low bits
   always_comb begin
      assert_mul_lsb_R8: assert (p_o[0] == (a_i[0] & b_i[0]));
   end

endmodule

// File: rtl/alu_snm_unit.sv
module alu_snm_unit
   import alu_snm_pkg::*;
#(
   parameter int W = 8,
   parameter int HALF_BIT = W / 2,
   parameter bit MUL_ARRAY = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     op_i,
   input  logic [W-1:0]   acc_i,
   input  logic [W-1:0]   opnd_i,
   input  logic           carry_i,
   output logic [W-1:0]   result_o,
   output logic [2*W-1:0] product_o,
   output logic           flag_n_o,
   output logic           flag_ov_o,
   output logic           flag_z_o,
   output logic           flag_dc_o,
   output logic           flag_c_o,
   output logic [4:0]     flag_upd_o
);
   localparam int PW = 2 * W;

   generate
      if (W < 4 || HALF_BIT < 1 || HALF_BIT >= W) begin : g_bad_cfg
         $error("alu_snm_unit: unsupported width or nibble split");
      end
   endgenerate

   op_e          op;
   logic [W-1:0] sub_a, sub_b;
   logic         sub_cin;
   logic         is_arith, is_mul;
   logic [W-1:0] sub_res;
   logic         sub_c, sub_dc, sub_ov;
   logic [PW-1:0] mul_p;

   always_comb begin
      op       = op_e'(op_i);
      sub_a    = opnd_i;
      sub_b    = acc_i;
      sub_cin  = 1'b1;
      is_arith = 1'b0;
      is_mul   = 1'b0;
      unique case (op)
         OP_SUB:    begin is_arith = 1'b1; end
         OP_SUBB_F: begin is_arith = 1'b1; sub_cin = carry_i; end
         OP_SUBB_W: begin is_arith = 1'b1; sub_a = acc_i; sub_b = opnd_i; sub_cin = carry_i; end
         OP_NEG:    begin is_arith = 1'b1; sub_a = '0; sub_b = opnd_i; end
         OP_MUL:    begin is_mul = 1'b1; end
         default:   begin end
      endcase
   end

   alu_snm_sub #(.W(W), .H(HALF_BIT)) u_sub (
      .a_i    (sub_a),
      .b_i    (sub_b),
      .cin_i  (sub_cin),
      .res_o  (sub_res),
      .cout_o (sub_c),
      .hcout_o(sub_dc),
      .ovf_o  (sub_ov)
   );

   alu_snm_mul #(.W(W), .USE_ARRAY(MUL_ARRAY)) u_mul (
      .a_i(acc_i),
      .b_i(opnd_i),
      .p_o(mul_p)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o   <= '0;
         product_o  <= '0;
         flag_n_o   <= 1'b0;
         flag_ov_o  <= 1'b0;
         flag_z_o   <= 1'b0;
         flag_dc_o  <= 1'b0;
         flag_c_o   <= 1'b0;
         flag_upd_o <= '0;
      end else begin
         flag_upd_o <= is_arith ? {NUM_FLAGS{1'b1}} : '0;
         if (is_arith) begin
            result_o  <= sub_res;
            flag_n_o  <= sub_res[W-1];
            flag_ov_o <= sub_ov;
            flag_z_o  <= (sub_res == '0);
            flag_dc_o <= sub_dc;
            flag_c_o  <= sub_c;
         end
         if (is_mul) product_o <= mul_p;
      end
   end

   // R8 / R9: the product register moves only on a multiply
   assert_prod_only_mul_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !is_mul |=> $stable(product_o));

   // R8: a multiply leaves result and flags untouched
   assert_mul_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_mul |=> ($stable(result_o) && $stable(flag_c_o) && $stable(flag_z_o) && flag_upd_o == '0));

   // R10: idle codes change nothing visible
   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_arith && !is_mul) |=> ($stable(result_o) && $stable(product_o) && flag_upd_o == '0));

   // R9: arithmetic ops mark every flag as defined
   assert_arith_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      is_arith |=> ($countones(flag_upd_o) == NUM_FLAGS));

   // R7: zero and negative flags are mutually exclusive after arithmetic
   assert_zn_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_arith |=> !(flag_z_o && flag_n_o));

endmodule

// File: tb/alu_snm_unit_test.sv
module alu_snm_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = 3'b000;
   logic [7:0]  acc_i = 8'h00;
   logic [7:0]  opnd_i = 8'h00;
   logic        carry_i = 1'b0;
   logic [7:0]  result_o;
   logic [15:0] product_o;
   logic        flag_n_o, flag_ov_o, flag_z_o, flag_dc_o, flag_c_o;
   logic [4:0]  flag_upd_o;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_snm_unit uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
      .carry_i(carry_i), .result_o(result_o), .product_o(product_o),
      .flag_n_o(flag_n_o), .flag_ov_o(flag_ov_o), .flag_z_o(flag_z_o),
      .flag_dc_o(flag_dc_o), .flag_c_o(flag_c_o), .flag_upd_o(flag_upd_o)
   );

   function automatic int sx(input int v);
      return (v >= 128) ? v - 256 : v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one op, wait an edge, sample 1 time unit later
   task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f, input logic c);
      @(negedge clk);
      op_i = op; acc_i = a; opnd_i = f; carry_i = c;
      @(posedge clk);
      #1;
   endtask

   // expected flags of x - y - bor, packed {N,OV,Z,DC,C,res[7:0]}
   function automatic logic [12:0] model(input int x, input int y, input int bor);
      int full, r, nib, sd;
      full = x - y - bor;
      r    = full & 255;
      nib  = (x & 15) - (y & 15) - bor;
      sd   = sx(x) - sx(y) - bor;
      return {r[7], (sd < -128 || sd > 127), (r == 0), (nib >= 0), (full >= 0), r[7:0]};
   endfunction

   task automatic arith_check(input string req, input logic [2:0] op, input int a, input int f, input int c);
      logic [12:0] e;
      apply(op, a[7:0], f[7:0], c[0]);
      case (op)
         3'b001:  e = model(f, a, 0);
         3'b010:  e = model(a, f, 1 - c);
         3'b011:  e = model(f, a, 1 - c);
         default: e = model(0, f, 0);
      endcase
      check(req, {19'd0, flag_n_o, flag_ov_o, flag_z_o, flag_dc_o, flag_c_o, result_o}, {19'd0, e});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] p0;
      logic [7:0]  r0;
      // R1: reset state
      op_i = 3'b001; acc_i = 8'h05; opnd_i = 8'h03;
      repeat (3) @(posedge clk);
      #1;
      check("R1", {product_o, result_o, flag_upd_o, flag_c_o, flag_z_o}, 32'd0);
      check("R1", {29'd0, flag_n_o, flag_ov_o, flag_dc_o}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R6: worked examples (operand minus accumulator)
      apply(3'b001, 8'd0, 8'd1, 1'b0);
      check("R6", {22'd0, result_o, flag_c_o, flag_z_o}, {22'd0, 8'd1, 1'b1, 1'b0});
      apply(3'b001, 8'd1, 8'd1, 1'b0);
      check("R6", {22'd0, result_o, flag_c_o, flag_z_o}, {22'd0, 8'd0, 1'b1, 1'b1});
      apply(3'b001, 8'd2, 8'd1, 1'b0);
      check("R6", {22'd0, result_o, flag_c_o, flag_z_o}, {22'd0, 8'hFF, 1'b0, 1'b0});

      // R5: negate corners
      apply(3'b100, 8'h33, 8'h00, 1'b0);
      check("R5", {22'd0, result_o, flag_c_o, flag_z_o}, {22'd0, 8'h00, 1'b1, 1'b1});
      apply(3'b100, 8'h33, 8'h80, 1'b0);
      check("R5", {21'd0, result_o, flag_ov_o, flag_c_o, flag_n_o}, {21'd0, 8'h80, 1'b1, 1'b0, 1'b1});

      // R2 R3 R4 R5 R6 R7 R9: sweeps
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 256; a++)
            for (int f = 0; f < 256; f += 17) begin
               arith_check("R2_R6_R7", 3'b001, a, f, c);
               arith_check("R3_R6_R7", 3'b010, a, f, c);
               arith_check("R4_R6_R7", 3'b011, a, f, c);
               if (a == 0) arith_check("R5_R6_R7", 3'b100, a, f, c);
            end
      for (int f = 0; f < 256; f++) arith_check("R5_R6_R7", 3'b100, 7, f, 0);

      // R9: update mask and product hold
      p0 = product_o;
      apply(3'b011, 8'h12, 8'h34, 1'b1);
      check("R9", {11'd0, flag_upd_o, product_o}, {11'd0, 5'b11111, p0});

      // R8: multiply sweep, result and flags hold
      apply(3'b001, 8'h10, 8'h25, 1'b1);
      r0 = result_o;
      for (int a = 0; a < 256; a++)
         for (int f = 0; f < 256; f += 5) begin
            apply(3'b101, a[7:0], f[7:0], 1'b0);
            check("R8", {16'd0, product_o}, a * f);
         end
      check("R8", {19'd0, flag_upd_o, result_o}, {19'd0, 5'd0, r0});
      check("R8", {27'd0, flag_n_o, flag_ov_o, flag_z_o, flag_dc_o, flag_c_o}, {27'd0, 5'b00011});

      // R10: idle codes
      apply(3'b101, 8'd200, 8'd201, 1'b0);
      apply(3'b011, 8'h01, 8'h80, 1'b1);
      p0 = product_o; r0 = result_o;
      for (int k = 0; k < 3; k++) begin
         apply((k == 0) ? 3'b000 : (k == 1) ? 3'b110 : 3'b111, 8'hAA, 8'h55, 1'b0);
         check("R10", {3'd0, flag_upd_o, product_o, result_o}, {3'd0, 5'd0, p0, r0});
         check("R10", {27'd0, flag_n_o, flag_ov_o, flag_z_o, flag_dc_o, flag_c_o}, {27'd0, 5'b01001});
      end

      // R11: chained 16-bit subtract B - C
      for (int t = 0; t < 40; t++) begin
         int b16, c16, d;
         logic [7:0] lo;
         b16 = (t * 12345 + 777) & 16'hFFFF;
         c16 = (t * 40503 + 91) & 16'hFFFF;
         if (t == 0) c16 = b16;
         if (t == 1) begin b16 = 16'h0100; c16 = 16'h0001; end
         d = b16 - c16;
         apply(3'b001, c16[7:0], b16[7:0], 1'b0);
         lo = result_o;
         apply(3'b010, b16[15:8], c16[15:8], flag_c_o);
         check("R11", {15'd0, flag_c_o, result_o, lo}, {15'd0, (d >= 0), d[15:0]});
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule